// File: doc/BRIEF.md
# Network Spike Vector Register with Step Delay

This block collects the per-step firing results of several neuron-processing units and merges them into one network-wide spike vector, one bit per neuron, where a 1 means that neuron fired during the step. At each step tick it starts every unit together. It then waits until each unit has reported completion with a one-cycle done pulse. Each unit's sub-vector is taken at the moment of its own done pulse. Only when all units have reported is the merged vector pushed.

The pushed vector enters a register chain whose length, `DELAY_STEPS` (1 to 10 steps), is fixed at design time. It models the time a spike takes to reach its targets. The end of the chain is broadcast to every unit as the presynaptic activity, because the network is fully connected. The undelayed vector of each step is also presented with a one-cycle valid pulse so it can be streamed to a host. A tick that arrives while a step is still running is ignored and raises a sticky overrun flag.

Top module: `spike_net_reg`

## Requirements
- R1: After reset, `fbSpikes`, `hostSpikes`, `hostValid`, `overrun` and `unitStart` are all zero, and the whole delay chain holds zeros.
- R2: A `stepTick` sampled while no step is running produces a `unitStart` pulse that is high for exactly the one cycle after that edge.
- R3: Unit u owns bits [u*NEUR_PER_UNIT +: NEUR_PER_UNIT] of the merged vector. That slice is taken from the same bits of `unitSpikes` at the edge where `unitDone[u]` is sampled high during the step. The other bits of `unitSpikes` at that edge have no effect.
- R4: Let the last outstanding done pulse be sampled at edge E. Then `hostValid` is low after E, high for exactly the one cycle after E+1, and the push happens at E+1. No push happens while any unit has not reported.
- R5: When `hostValid` is high, `hostSpikes` equals the merged, undelayed vector of the step just completed.
- R6: After the k-th push, `fbSpikes` equals the vector of push k-DELAY_STEPS+1. Before DELAY_STEPS pushes have occurred, it is zero.
- R7: `fbSpikes` changes only in the cycle in which `hostValid` is high.
- R8: A `stepTick` sampled while a step is running sets `overrun`, which stays set until reset. It produces no `unitStart` and does not disturb the running step.
- R9: Done pulses sampled while no step is running are ignored. A later step still waits for a fresh done pulse from every unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepTick | input | 1 | Simulation step tick |
| unitSpikes | input | NUM_UNITS*NEUR_PER_UNIT | Sub-vectors from all units, unit u in its own slice |
| unitDone | input | NUM_UNITS | One-cycle completion pulse per unit |
| unitStart | output | 1 | Start pulse broadcast to all units |
| fbSpikes | output | NUM_UNITS*NEUR_PER_UNIT | Delayed network vector fed back to all units |
| hostSpikes | output | NUM_UNITS*NEUR_PER_UNIT | Undelayed vector of the latest step |
| hostValid | output | 1 | One-cycle strobe qualifying hostSpikes |
| overrun | output | 1 | Sticky flag: a tick arrived during a running step |

## Verification
`unitStart` is due one cycle after the tick edge. `hostValid`, `hostSpikes` and the new `fbSpikes` are due one cycle after the edge that samples the last done pulse. The bench drives all inputs on the falling edge and reads outputs on the next falling edge. It checks for `unitStart` at the first falling edge after the tick and for its absence one cycle later. After the last done pulse, it checks that `hostValid` is still low at the next falling edge and high at the one after. A queue holds the expected undelayed vector and the expected delayed vector for each step, and is popped whenever the valid strobe is seen. Any change of the feedback vector outside a valid cycle is flagged.

// File: rtl/spk_pkg.sv
package spk_pkg;
  // strobes from the step sequencer to the vector datapath
  typedef struct packed {
    logic collect;  // step running, not all units reported yet
    logic push;     // all units reported: shift merged vector in
  } spkStrobe_t;
endpackage

// File: rtl/spk_ctrl.sv
module spk_ctrl
  import spk_pkg::*;
#(
  parameter int NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stepTick,
  input  logic [NUM_UNITS-1:0] unitDone,
  output spkStrobe_t           str,
  output logic                 unitStart,
  output logic                 overrun
);
  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t               state;
  logic [NUM_UNITS-1:0] doneMask;
  logic                 allDone;

  assign allDone = &doneMask;

  always_comb begin
    str.collect = (state == S_RUN) && !allDone;
    str.push    = (state == S_RUN) && allDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      doneMask  <= '0;
      unitStart <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      unitStart <= 1'b0;
      case (state)
        S_IDLE: begin
          if (stepTick) begin
            state     <= S_RUN;
            doneMask  <= '0;
            unitStart <= 1'b1;
          end
        end
        S_RUN: begin
          if (stepTick) overrun <= 1'b1;
          if (allDone) state <= S_IDLE;
          else doneMask <= doneMask | unitDone;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spk_path.sv
module spk_path
  import spk_pkg::*;
#(
  parameter int NUM_UNITS     = 4,
  parameter int NEUR_PER_UNIT = 8,
  parameter int DELAY_STEPS   = 3
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  spkStrobe_t                          str,
  input  logic [NUM_UNITS*NEUR_PER_UNIT-1:0]  unitSpikes,
  input  logic [NUM_UNITS-1:0]                unitDone,
  output logic [NUM_UNITS*NEUR_PER_UNIT-1:0]  fbSpikes,
  output logic [NUM_UNITS*NEUR_PER_UNIT-1:0]  hostSpikes,
  output logic                                hostValid
);
  localparam int TOTAL = NUM_UNITS * NEUR_PER_UNIT;

  logic [NEUR_PER_UNIT-1:0] slot [NUM_UNITS];
  logic [TOTAL-1:0]         staged;
  logic [TOTAL-1:0]         chain [DELAY_STEPS];

  // one staging slot per unit, loaded on that unit's done pulse
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) slot[u] <= '0;
      else if (str.collect && unitDone[u])
        slot[u] <= unitSpikes[u*NEUR_PER_UNIT +: NEUR_PER_UNIT];
    end
    assign staged[u*NEUR_PER_UNIT +: NEUR_PER_UNIT] = slot[u];
  end

  // step-delay chain, advanced once per completed step
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DELAY_STEPS; i++) chain[i] <= '0;
    end else if (str.push) begin
      chain[0] <= staged;
      for (int i = 1; i < DELAY_STEPS; i++) chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostSpikes <= '0;
      hostValid  <= 1'b0;
    end else begin
      hostValid <= str.push;
      if (str.push) hostSpikes <= staged;
    end
  end

  assign fbSpikes = chain[DELAY_STEPS-1];
endmodule

// File: rtl/spike_net_reg.sv
module spike_net_reg
  import spk_pkg::*;
#(
  parameter int NUM_UNITS     = 4,
  parameter int NEUR_PER_UNIT = 8,
  parameter int DELAY_STEPS   = 3
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                stepTick,
  input  logic [NUM_UNITS*NEUR_PER_UNIT-1:0]  unitSpikes,
  input  logic [NUM_UNITS-1:0]                unitDone,
  output logic                                unitStart,
  output logic [NUM_UNITS*NEUR_PER_UNIT-1:0]  fbSpikes,
  output logic [NUM_UNITS*NEUR_PER_UNIT-1:0]  hostSpikes,
  output logic                                hostValid,
  output logic                                overrun
);
  spkStrobe_t str;

  spk_ctrl #(.NUM_UNITS(NUM_UNITS)) uCtrl (
    .clk(clk), .rstN(rstN), .stepTick(stepTick), .unitDone(unitDone),
    .str(str), .unitStart(unitStart), .overrun(overrun)
  );

  spk_path #(
    .NUM_UNITS(NUM_UNITS), .NEUR_PER_UNIT(NEUR_PER_UNIT), .DELAY_STEPS(DELAY_STEPS)
  ) uPath (
    .clk(clk), .rstN(rstN), .str(str), .unitSpikes(unitSpikes), .unitDone(unitDone),
    .fbSpikes(fbSpikes), .hostSpikes(hostSpikes), .hostValid(hostValid)
  );
endmodule

// File: rtl/spike_net_reg_chk.sv
module spike_net_reg_chk #(
  parameter int TOTAL = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             unitStart,
  input logic             hostValid,
  input logic [TOTAL-1:0] fbSpikes,
  input logic             overrun
);
  a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    unitStart |=> !unitStart);

  a_r4_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    hostValid |=> !hostValid);

  a_r4_no_push_after_start: assert property (@(posedge clk) disable iff (!rstN)
    unitStart |=> !hostValid);

  a_r7_fb_only_on_push: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fbSpikes) |-> hostValid);

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
endmodule

bind spike_net_reg spike_net_reg_chk #(.TOTAL(NUM_UNITS*NEUR_PER_UNIT)) uChk (
  .clk(clk), .rstN(rstN), .unitStart(unitStart), .hostValid(hostValid),
  .fbSpikes(fbSpikes), .overrun(overrun)
);

// File: tb/sim_spike_net_reg.sv
module sim_spike_net_reg;
  localparam int U = 4;
  localparam int M = 8;
  localparam int D = 3;
  localparam int N = U * M;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         stepTick = 1'b0;
  logic [N-1:0] unitSpikes = '0;
  logic [U-1:0] unitDone = '0;
  logic         unitStart, hostValid, overrun;
  logic [N-1:0] fbSpikes, hostSpikes;

  int total = 0;
  int bad = 0;
  int pushCount = 0;
  logic [N-1:0] hist [0:63];
  logic [N-1:0] qHost [$];
  logic [N-1:0] qFb [$];
  logic [N-1:0] prevFb = '0;

  always #4 clk = ~clk;

  spike_net_reg #(.NUM_UNITS(U), .NEUR_PER_UNIT(M), .DELAY_STEPS(D)) u0 (
    .clk(clk), .rstN(rstN), .stepTick(stepTick), .unitSpikes(unitSpikes),
    .unitDone(unitDone), .unitStart(unitStart), .fbSpikes(fbSpikes),
    .hostSpikes(hostSpikes), .hostValid(hostValid), .overrun(overrun)
  );

  task automatic check(input logic ok, input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard driver side: record what the next push must show
  task automatic expectPush(input logic [N-1:0] vec);
    pushCount++;
    hist[pushCount] = vec;
    qHost.push_back(vec);
    qFb.push_back((pushCount >= D) ? hist[pushCount-D+1] : '0);
  endtask

  // unit u reports; the rest of the bus carries inverted junk (R3)
  task automatic pulseDone(input int u, input logic [N-1:0] vec);
    unitSpikes = ~vec;
    unitSpikes[u*M +: M] = vec[u*M +: M];
    unitDone = '0;
    unitDone[u] = 1'b1;
    @(negedge clk);
    unitDone = '0;
    unitSpikes = '0;
  endtask

  task automatic tickAndStart();
    stepTick = 1'b1;
    @(negedge clk);
    stepTick = 1'b0;
    check(unitStart == 1'b1, "R2 start high", N'(unitStart), N'(1));
    @(negedge clk);
    check(unitStart == 1'b0, "R2 start one cycle", N'(unitStart), N'(0));
  endtask

  task automatic finalCheck();
    check(hostValid == 1'b0, "R4 valid not early", N'(hostValid), N'(0));
    @(negedge clk);
    check(hostValid == 1'b1, "R4 valid due", N'(hostValid), N'(1));
  endtask

  // order: 0 ascending with gaps, 1 descending, 2 all together
  task automatic runStep(input logic [N-1:0] vec, input int order);
    tickAndStart();
    expectPush(vec);
    if (order == 2) begin
      unitSpikes = vec;
      unitDone = '1;
      @(negedge clk);
      unitDone = '0;
      unitSpikes = '0;
      finalCheck();
    end else begin
      for (int i = 0; i < U; i++) begin
        pulseDone((order == 0) ? i : U-1-i, vec);
        if (i == U-1) finalCheck();
        else if (order == 0) @(negedge clk);
      end
    end
    @(negedge clk);
  endtask

  // monitor: compares each pushed result with the scoreboard (R5, R6, R7)
  always @(negedge clk) begin
    if (rstN) begin
      if (hostValid) begin
        if (qHost.size() == 0) begin
          check(1'b0, "R4 unexpected push", hostSpikes, '0);
        end else begin
          logic [N-1:0] eh, ef;
          eh = qHost.pop_front();
          ef = qFb.pop_front();
          check(hostSpikes == eh, "R5 host vector", hostSpikes, eh);
          check(fbSpikes == ef, "R6 delayed feedback", fbSpikes, ef);
        end
      end else if (fbSpikes != prevFb) begin
        check(1'b0, "R7 feedback moved without push", fbSpikes, prevFb);
      end
      prevFb = fbSpikes;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(fbSpikes == '0, "R1 fb zero", fbSpikes, '0);
    check(hostSpikes == '0, "R1 host zero", hostSpikes, '0);
    check({hostValid, overrun, unitStart} == 3'b000, "R1 flags zero",
          N'({hostValid, overrun, unitStart}), '0);

    // R3 R5 R6: various orders and patterns
    runStep(32'hA5C3_0F81, 0);
    runStep(32'h1234_5678, 1);
    runStep(32'hFFFF_0000, 2);
    runStep(32'h0000_0001, 0);
    runStep(32'h8000_0000, 1);
    runStep(32'hDEAD_BEEF, 2);

    // R9: done pulses while idle are ignored
    pulseDone(3, 32'h5555_5555);
    unitSpikes = '1;
    unitDone = '1;
    @(negedge clk);
    unitDone = '0;
    unitSpikes = '0;
    repeat (3) @(negedge clk);
    check(hostValid == 1'b0, "R9 idle done no push", N'(hostValid), '0);
    tickAndStart();
    for (int i = 0; i < U-1; i++) pulseDone(i, 32'h0F0F_3C3C);
    begin
      int seen = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (hostValid) seen++;
      end
      check(seen == 0, "R9 R4 waits for last unit", N'(seen), '0);
    end
    expectPush(32'h0F0F_3C3C);
    pulseDone(U-1, 32'h0F0F_3C3C);
    finalCheck();
    @(negedge clk);

    // R8: tick while running
    tickAndStart();
    expectPush(32'h7777_1111);
    check(overrun == 1'b0, "R8 no overrun yet", N'(overrun), '0);
    stepTick = 1'b1;
    @(negedge clk);
    stepTick = 1'b0;
    check(overrun == 1'b1, "R8 overrun set", N'(overrun), N'(1));
    check(unitStart == 1'b0, "R8 no extra start", N'(unitStart), '0);
    unitSpikes = 32'h7777_1111;
    unitDone = '1;
    @(negedge clk);
    unitDone = '0;
    unitSpikes = '0;
    finalCheck();
    repeat (5) @(negedge clk);
    check(overrun == 1'b1, "R8 overrun sticky", N'(overrun), N'(1));
    check(qHost.size() == 0, "R4 all pushes seen", N'(qHost.size()), '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule